// File: doc/BRIEF.md
# Three-Phase Overcurrent Trip Latch

This block watches three phase-current sample streams that arrive already filtered and digitized, each sample accompanied by a shared valid strobe. Every phase has its own channel, and each channel runs two tests on every valid sample. The first test compares the sample's absolute value against a peak limit. The second compares the absolute difference from the previous valid sample against a rate limit. A channel that fails either test for a programmable number of consecutive valid samples sets its trip latch. That latch then holds until a global clear.

The three latches are ORed into one isolation signal. While isolation is high, every bit of the inverter gate-drive bus is forced low. The same signal also asserts a DC-breaker-open output and a filter-capacitor-disconnect output. The peak limit is normally set to the rated peak current times a tolerance slightly above unity. The rate limit is normally set to the rated peak derivative times the same tolerance. The persistence count keeps short switching transients from setting a latch.

Top module: `phase_trip_guard`

## Requirements
- R1: After reset all trip bits, `iso_o`, `dc_open_o` and `cap_off_o` are 0, and `gate_o` equals `gate_i`.
- R2: A valid sample whose absolute value is strictly greater than `mag_lim_i` counts as a violation. A sample whose absolute value equals the limit does not.
- R3: The absolute value of a negative sample is its magnitude. The code -32768 saturates to 32767, so it does not violate a limit of 32767.
- R4: A valid sample whose absolute difference from the previous valid sample on the same phase is strictly greater than `rate_lim_i` counts as a violation. The first valid sample after reset, after a clear, or after a cycle with `en_i` low has no slope test.
- R5: A channel's trip sets in the cycle after the Q-th consecutive violating valid sample, where Q is `qual_i`, and a value of 0 acts as 1. A compliant valid sample restarts the count. Cycles without `smp_vld_i` neither advance nor restart it.
- R6: A set trip holds until `clear_i` is high at a clock edge. `clear_i` clears all trips and counts and takes priority over a set in the same cycle.
- R7: `iso_o` is the OR of the three trip bits, and `dc_open_o` and `cap_off_o` equal `iso_o`.
- R8: `gate_o` equals `gate_i` while `iso_o` is low and is all zeros while `iso_o` is high.
- R9: While `en_i` is low, samples are ignored and the persistence counts restart. Trips that are already set hold.
- R10: The phases are independent, and `trip_o` bit 0, 1 and 2 belong to phases a, b and c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detection enable |
| clear_i | input | 1 | Synchronous clear of all trips |
| smp_vld_i | input | 1 | Sample strobe for all three phases |
| smp_a_i | input | 16 | Phase a sample, signed |
| smp_b_i | input | 16 | Phase b sample, signed |
| smp_c_i | input | 16 | Phase c sample, signed |
| rate_lim_i | input | 16 | Slope limit, unsigned |
| mag_lim_i | input | 16 | Peak limit, unsigned |
| qual_i | input | 8 | Persistence count |
| gate_i | input | 6 | Gate bus from the controller |
| gate_o | output | 6 | Gate bus after blanking |
| trip_o | output | 3 | Per-phase latched trips |
| iso_o | output | 1 | Isolation request |
| dc_open_o | output | 1 | DC breaker open command |
| cap_off_o | output | 1 | Filter capacitor disconnect |

## Verification
The hardest behaviour to reach is the persistence count being restarted or held by things other than a compliant sample. These include an invalid cycle placed between violations, a drop of `en_i`, and a clear that arrives together with the qualifying violation. The stimulus builds runs of violating samples one short of the count. It then interleaves invalid cycles, compliant samples, enable drops and clears, and shows that the latch sets only on a clean, uninterrupted run. Slope-only violations are driven with a generous peak limit. In those cases the first sample after a clear must not be tested against a stale previous value.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned THR_W  = 16;
  localparam int unsigned QUAL_W = 8;
  localparam int unsigned N_PH   = 3;
  localparam int unsigned GATE_N = 6;
endpackage

// File: rtl/abs_sat.sv
module abs_sat #(
  parameter int unsigned W = 16
) (
  input  logic signed [W-1:0] x_i,
  output logic        [W-2:0] mag_o
);
  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
  logic [W-1:0] neg;

  always_comb begin
    neg = -x_i;
    if (!x_i[W-1])               mag_o = x_i[W-2:0];
    else if (x_i == MIN_CODE)    mag_o = '1;
    else                         mag_o = neg[W-2:0];
  end
endmodule

// File: rtl/persist_ctr.sv
module persist_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic          hit_i,
  input  logic [CW-1:0] lim_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   run_nxt;
  logic [CW:0]   lim_eff;

  always_comb begin
    run_nxt = {1'b0, cnt_q} + 1'b1;
    lim_eff = (lim_i == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, lim_i};
    fire_o  = step_i && hit_i && (run_nxt >= lim_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || restart_i) cnt_q <= '0;
    else if (step_i) begin
      if (!hit_i)               cnt_q <= '0;
      else if (!run_nxt[CW])    cnt_q <= run_nxt[CW-1:0];
    end
  end

  // R5: a compliant sample restarts the run
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !hit_i) |=> (cnt_q == '0));
endmodule

// File: rtl/phase_chan.sv
module phase_chan
  import trip_pkg::*;
#(
  parameter int unsigned SW = SMP_W,
  parameter int unsigned TW = THR_W,
  parameter int unsigned QW = QUAL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 vld_i,
  input  logic signed [SW-1:0] smp_i,
  input  logic        [TW-1:0] rate_lim_i,
  input  logic        [TW-1:0] mag_lim_i,
  input  logic        [QW-1:0] qual_i,
  output logic                 trip_o
);
  logic signed [SW-1:0] prev_q;
  logic                 have_prev_q;
  logic signed [SW:0]   diff;
  logic        [SW-2:0] abs_smp;
  logic        [SW-1:0] abs_diff;
  logic                 mag_hit, slope_hit, step, fire;

  assign diff = {smp_i[SW-1], smp_i} - {prev_q[SW-1], prev_q};

  abs_sat #(.W(SW))   u_abs_smp  (.x_i(smp_i), .mag_o(abs_smp));
  abs_sat #(.W(SW+1)) u_abs_diff (.x_i(diff),  .mag_o(abs_diff));

  assign mag_hit   = TW'(abs_smp) > mag_lim_i;
  assign slope_hit = have_prev_q && (TW'(abs_diff) > rate_lim_i);
  assign step      = vld_i && en_i;

  persist_ctr #(.CW(QW)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .restart_i(!en_i),
    .step_i   (step),
    .hit_i    (mag_hit || slope_hit),
    .lim_i    (qual_i),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (clr_i || !en_i) begin
      have_prev_q <= 1'b0;
    end else if (vld_i) begin
      prev_q      <= smp_i;
      have_prev_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trip_o <= 1'b0;
    else if (clr_i)  trip_o <= 1'b0;
    else if (fire)   trip_o <= 1'b1;
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_o && !clr_i) |=> trip_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !trip_o);
  a_r9_no_set_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !trip_o) |=> !trip_o);
  a_r5_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !trip_o) |=> !trip_o);
endmodule

// File: rtl/phase_trip_guard.sv
module phase_trip_guard
  import trip_pkg::*;
#(
  parameter int unsigned SW = SMP_W,
  parameter int unsigned TW = THR_W,
  parameter int unsigned QW = QUAL_W,
  parameter int unsigned GN = GATE_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clear_i,
  input  logic                 smp_vld_i,
  input  logic signed [SW-1:0] smp_a_i,
  input  logic signed [SW-1:0] smp_b_i,
  input  logic signed [SW-1:0] smp_c_i,
  input  logic        [TW-1:0] rate_lim_i,
  input  logic        [TW-1:0] mag_lim_i,
  input  logic        [QW-1:0] qual_i,
  input  logic        [GN-1:0] gate_i,
  output logic        [GN-1:0] gate_o,
  output logic      [N_PH-1:0] trip_o,
  output logic                 iso_o,
  output logic                 dc_open_o,
  output logic                 cap_off_o
);
  logic signed [SW-1:0] smp [N_PH];

  assign smp[0] = smp_a_i;
  assign smp[1] = smp_b_i;
  assign smp[2] = smp_c_i;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    phase_chan #(.SW(SW), .TW(TW), .QW(QW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clear_i),
      .en_i      (en_i),
      .vld_i     (smp_vld_i),
      .smp_i     (smp[p]),
      .rate_lim_i(rate_lim_i),
      .mag_lim_i (mag_lim_i),
      .qual_i    (qual_i),
      .trip_o    (trip_o[p])
    );
  end

  assign iso_o     = |trip_o;
  assign dc_open_o = iso_o;
  assign cap_off_o = iso_o;
  assign gate_o    = gate_i & {GN{~iso_o}};

  // R7: isolation only rises after an enabled, valid, uncleared sample
  a_r7_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> $past(smp_vld_i && en_i && !clear_i));
  // R6: clear drops isolation
  a_r6_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !iso_o);
endmodule

// File: tb/sim_phase_trip_guard.sv
module sim_phase_trip_guard;
  localparam time CLK_P = 10ns;

  logic clk = 0, rst_ni = 0;
  logic en_i = 0, clear_i = 0, vld_i = 0;
  logic signed [15:0] a_i = 0, b_i = 0, c_i = 0;
  logic [15:0] rate_i = 0, mag_i = 0;
  logic [7:0]  qual_i = 0;
  logic [5:0]  gate_i = 0, gate_o;
  logic [2:0]  trip_o;
  logic iso_o, dc_o, cap_o;

  phase_trip_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .clear_i(clear_i),
    .smp_vld_i(vld_i), .smp_a_i(a_i), .smp_b_i(b_i), .smp_c_i(c_i),
    .rate_lim_i(rate_i), .mag_lim_i(mag_i), .qual_i(qual_i),
    .gate_i(gate_i), .gate_o(gate_o), .trip_o(trip_o), .iso_o(iso_o),
    .dc_open_o(dc_o), .cap_off_o(cap_o)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { int due; logic [2:0] trip; logic [5:0] gate; string tag; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // shadow controls, applied by step
  int sh_rate = 0, sh_mag = 0, sh_qual = 1, sh_gate = 0;
  // reference state
  int prev[3], run[3];
  bit hp[3], lat[3];

  function automatic int sabs(int v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction

  task automatic step(bit v, bit en, bit clr, int a, int b, int c, string tag);
    int s[3];
    item_t it;
    int qe;
    @(posedge clk); #2;
    vld_i = v; en_i = en; clear_i = clr;
    a_i = 16'(a); b_i = 16'(b); c_i = 16'(c);
    rate_i = 16'(sh_rate); mag_i = 16'(sh_mag); qual_i = 8'(sh_qual); gate_i = 6'(sh_gate);
    s[0] = a; s[1] = b; s[2] = c;
    qe = (sh_qual == 0) ? 1 : sh_qual;
    for (int p = 0; p < 3; p++) begin
      if (clr) begin lat[p] = 0; run[p] = 0; hp[p] = 0; end
      else if (!en) begin run[p] = 0; hp[p] = 0; end
      else if (v) begin
        bit viol;
        viol = (sabs(s[p]) > sh_mag) || (hp[p] && sabs(s[p] - prev[p]) > sh_rate);
        if (viol) begin
          if (run[p] < 255) run[p]++;
          else if (qe > 255) ;
          if (run[p] >= qe || (run[p] == 255 && qe <= 256 && run[p] + 1 >= qe)) lat[p] = 1;
        end else run[p] = 0;
        prev[p] = s[p]; hp[p] = 1;
      end
    end
    it.due = cyc + 1;
    it.trip = {lat[2], lat[1], lat[0]};
    it.gate = (|it.trip) ? 6'd0 : 6'(sh_gate);
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        logic exp_iso;
        it = q.pop_front();
        exp_iso = |it.trip;
        checks++;
        if (trip_o !== it.trip || iso_o !== exp_iso || dc_o !== exp_iso ||
            cap_o !== exp_iso || gate_o !== it.gate) begin
          errors++;
          $display("FAIL %s: trip=%b iso=%b dc=%b cap=%b gate=%h, expected trip=%b iso=%b gate=%h",
                   it.tag, trip_o, iso_o, dc_o, cap_o, gate_o, it.trip, exp_iso, it.gate);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    for (int p = 0; p < 3; p++) begin prev[p] = 0; run[p] = 0; hp[p] = 0; lat[p] = 0; end
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    sh_gate = 6'h2A; sh_rate = 65535; sh_mag = 1000; sh_qual = 1;
    step(0, 1, 0, 0, 0, 0, "R1 reset state");
    // magnitude
    step(1, 1, 0, 1000, 0, 0, "R2 equal to limit");
    step(1, 1, 0, 1001, 0, 0, "R2 above limit, R7 R8 blank");
    step(0, 1, 0, 0, 0, 0, "R6 hold without clear");
    step(1, 1, 1, 0, 0, 0, "R6 clear");
    // negative
    step(1, 1, 0, 0, -1001, 0, "R3 negative trips, R10 phase b");
    step(1, 1, 1, 0, 0, 0, "R6 clear");
    sh_mag = 32767;
    step(1, 1, 0, 0, 0, -32768, "R3 saturated code no trip");
    step(1, 1, 1, 0, 0, 0, "R6 clear");
    // slope
    sh_mag = 30000; sh_rate = 100;
    step(1, 1, 0, 0, 0, 0, "R4 base");
    step(1, 1, 0, 100, 0, 0, "R4 diff equal");
    step(1, 1, 0, 201, 0, 0, "R4 diff above");
    step(1, 1, 1, 0, 0, 0, "R6 clear");
    step(1, 1, 0, 5000, 0, 0, "R4 first after clear untested");
    step(1, 1, 0, 5050, 0, 0, "R4 small step");
    step(0, 0, 0, 0, 0, 0, "R9 enable drop");
    step(1, 1, 0, -5000, 0, 0, "R4 first after enable untested");
    // persistence
    sh_rate = 65535; sh_mag = 1000; sh_qual = 3;
    step(1, 1, 0, 2000, 0, 0, "R5 run 1");
    step(1, 1, 0, 2000, 0, 0, "R5 run 2");
    step(1, 1, 0, 500, 0, 0, "R5 compliant restarts");
    step(1, 1, 0, 2000, 0, 0, "R5 run 1");
    step(1, 1, 0, 2000, 0, 0, "R5 run 2");
    step(0, 1, 0, 0, 0, 0, "R5 invalid holds count");
    step(1, 1, 0, 2000, 0, 0, "R5 run 3 sets");
    step(1, 1, 1, 0, 0, 0, "R6 clear");
    sh_qual = 0;
    step(1, 1, 0, 0, 0, 2000, "R5 zero acts as one, R10 phase c");
    step(1, 1, 1, 0, 0, 0, "R6 clear");
    // enable
    sh_qual = 2;
    step(1, 0, 0, 2000, 2000, 2000, "R9 disabled ignored");
    step(1, 0, 0, 2000, 2000, 2000, "R9 disabled ignored");
    step(1, 1, 0, 2000, 0, 0, "R9 run 1");
    step(1, 0, 0, 2000, 0, 0, "R9 drop restarts");
    step(1, 1, 0, 2000, 0, 0, "R9 run 1 again");
    step(1, 1, 0, 2000, 0, 0, "R9 run 2 sets");
    step(1, 0, 0, 0, 0, 0, "R9 latch holds while disabled");
    step(1, 1, 0, 0, 0, 0, "R6 still held");
    // clear wins over set
    sh_qual = 1;
    step(1, 1, 1, 2000, 2000, 0, "R6 clear priority");
    step(1, 1, 0, 0, 0, 0, "R6 stays clear");
    sh_gate = 6'h15;
    step(1, 1, 0, 0, 0, 0, "R8 gate pass");
    step(1, 1, 0, 0, 3000, 0, "R10 only phase b, R7");
    step(0, 1, 0, 0, 0, 0, "R8 blanked");
    repeat (4) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL queue: %0d items left, expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule